// File: doc/BRIEF.md
# Host Port Interface Slave

This block is a slave port through which an external host reads and writes a 32-bit internal memory over a 16-bit asynchronous bus. The host selects one of three 32-bit registers (a control register, an address register or a data register) through two control bits. Each register moves as two half-word transfers, low half first, chosen by a half-word identifier. A data-register access turns into a word read or word write on an internal memory port with a request/acknowledge handshake. The address can optionally advance by four bytes after every completed word.

Every host input passes through a two-flop synchronizer before edge detection. The access strobe is active when chip select is low and the two data strobes differ. The select inputs are captured either on the falling edge of the optional address strobe or on the falling edge of the access strobe. An active-low ready output tells the host when it may release the strobe. Ready goes busy while a data read is fetched, and it goes busy again while a posted data write or an auto-increment prefetch completes. Ready is always shown ready while chip select is high.

Top module: `hpi_slave`

## Requirements
- R1: The internal access strobe is active only while chip select is low and exactly one of the two data strobes is low. With both data strobes low, a write leaves the addressed register unchanged.
- R2: When the address strobe falls before the access strobe, the select inputs captured at that address-strobe edge are used, and later changes on the select pins are ignored for that access.
- R3: The control bits select the register: 2'b00 the control register, 2'b10 the address register, 2'b01 the data register with auto-increment, and 2'b11 the data register with a fixed address. Control and address halves read back exactly what was written to them.
- R4: Half-word identifier 0 addresses bits 15:0 and 1 addresses bits 31:16. A data write reaches memory only after its second half, as the word {second half, first half}.
- R5: A first-half data read issues a memory read of the current address. Ready (active low) is high until the word is loaded, and the low half is then on the bus.
- R6: In auto-increment mode, the address advances by 4 after the memory write of a completed word. After a second-half read it advances by 4 and prefetches the next word, with ready high until the prefetch returns.
- R7: In fixed-address mode the address register is never changed by data accesses.
- R8: Ready is low whenever chip select is high. If chip select falls while a posted write or prefetch is outstanding, ready is high at once and stays high until that operation completes.
- R9: Control-register and address-register accesses never drive ready high.
- R10: The data bus is driven by the block only during a read access, and is released once chip select has been high for several clocks.
- R11: A memory request stays asserted, with a stable address, write flag and write data, until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs_n | input | 1 | Host chip select, active low |
| host_ds1_n | input | 1 | Host data strobe one |
| host_ds2_n | input | 1 | Host data strobe two |
| host_as_n | input | 1 | Optional address strobe; tie high when unused |
| host_ctl | input | 2 | Register select (00 control, 01 data+inc, 10 address, 11 data fixed) |
| host_rnw | input | 1 | 1 = host read, 0 = host write |
| host_hw | input | 1 | Half-word identifier, 0 = low half, 1 = high half |
| host_d | inout | 16 | Bidirectional host data bus |
| host_rdy_n | output | 1 | Ready, active low; high means wait |
| mem_req | output | 1 | Memory request, held until acknowledge |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write word |
| mem_rdata | input | 32 | Read word, valid with acknowledge |
| mem_ack | input | 1 | One-cycle acknowledge of the request |

## Verification
A table of host accesses exercises every register select with both half-words and both directions, against a memory model with a fixed latency. Control and address readbacks tell register steering apart from memory traffic. Reads following fixed and incrementing data writes separate the two address modes and show the half-word ordering in memory. Directed cases test a strobe pair that both go low, selects latched by the address strobe, a stalled acknowledge that shows the immediate busy on chip-select fall, and the absence of any memory write after a first half alone.

// File: rtl/hpi_pkg.sv
package hpi_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL     = 2'b00,
        SEL_DATA_INC = 2'b01,
        SEL_ADDR     = 2'b10,
        SEL_DATA_FIX = 2'b11
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e ctl;
        logic     rnw;
        logic     hw;
    } host_sel_t;

endpackage

// File: rtl/hpi_sync.sv
module hpi_sync #(
    parameter int               W       = 8,
    parameter logic [W-1:0]     RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
        end
    end

    assign dout = sync_q;
endmodule

// File: rtl/hpi_strobe.sv
module hpi_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic ds1_n,
    input  logic ds2_n,
    input  logic as_n,
    output logic stb_fall,
    output logic stb_rise,
    output logic as_fall
);
    logic stb_n;
    logic stb_q;
    logic as_q;

    // combined strobe: low only with chip select low and strobes differing
    assign stb_n = ~(ds1_n ^ ds2_n) | cs_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stb_q <= 1'b1;
            as_q  <= 1'b1;
        end else begin
            stb_q <= stb_n;
            as_q  <= as_n;
        end
    end

    assign stb_fall = stb_q & ~stb_n;
    assign stb_rise = ~stb_q & stb_n;
    assign as_fall  = as_q & ~as_n;
endmodule

// File: rtl/hpi_slave.sv
module hpi_slave
    import hpi_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int ADDR_STEP = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_cs_n,
    input  logic                host_ds1_n,
    input  logic                host_ds2_n,
    input  logic                host_as_n,
    input  logic [1:0]          host_ctl,
    input  logic                host_rnw,
    input  logic                host_hw,
    inout  wire  [WORD_W/2-1:0] host_d,
    output logic                host_rdy_n,
    output logic                mem_req,
    output logic                mem_we,
    output logic [WORD_W-1:0]   mem_addr,
    output logic [WORD_W-1:0]   mem_wdata,
    input  logic [WORD_W-1:0]   mem_rdata,
    input  logic                mem_ack
);
    localparam int HALF_W = WORD_W / 2;
    localparam int CTL_W  = 8;
    localparam int SYNC_W = CTL_W + HALF_W;
    localparam logic [SYNC_W-1:0] SYNC_RST = {4'b1111, {(SYNC_W-4){1'b0}}};

    typedef struct packed {
        logic [WORD_W-1:0] ctrl;
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] data;
        logic [HALF_W-1:0] wlo;
        host_sel_t         acc;
        host_sel_t         as_sel;
        logic              as_hit;
        logic              drv;
        logic              req;
        logic              we;
        logic              inc;
    } state_t;

    state_t st_d, st_q;

    logic [SYNC_W-1:0] raw_in, syn;
    logic              s_cs_n, s_ds1_n, s_ds2_n, s_as_n, s_rnw, s_hw;
    logic [1:0]        s_ctl;
    logic [HALF_W-1:0] s_d;
    logic              stb_fall, stb_rise, as_fall;
    logic [WORD_W-1:0] rd_word;
    logic [HALF_W-1:0] rd_half;
    logic              drv_oe;

    assign raw_in = {host_cs_n, host_ds1_n, host_ds2_n, host_as_n,
                     host_ctl, host_rnw, host_hw, host_d};

    hpi_sync #(.W(SYNC_W), .RST_VAL(SYNC_RST)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_in),
        .dout (syn)
    );

    assign {s_cs_n, s_ds1_n, s_ds2_n, s_as_n, s_ctl, s_rnw, s_hw, s_d} = syn;

    hpi_strobe u_stb (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (s_cs_n),
        .ds1_n   (s_ds1_n),
        .ds2_n   (s_ds2_n),
        .as_n    (s_as_n),
        .stb_fall(stb_fall),
        .stb_rise(stb_rise),
        .as_fall (as_fall)
    );

    always_comb begin
        host_sel_t sel_now;
        st_d    = st_q;
        sel_now = '{ctl: reg_sel_e'(s_ctl), rnw: s_rnw, hw: s_hw};

        if (as_fall) begin
            st_d.as_sel = sel_now;
            st_d.as_hit = 1'b1;
        end

        if (stb_fall) begin
            st_d.acc = st_q.as_hit ? st_q.as_sel : sel_now;
            st_d.drv = st_d.acc.rnw;
            // first half of a data read fetches the word
            if (st_d.acc.rnw && st_d.acc.ctl[0] && !st_d.acc.hw) begin
                st_d.req = 1'b1;
                st_d.we  = 1'b0;
                st_d.inc = 1'b0;
            end
        end

        if (stb_rise) begin
            st_d.drv    = 1'b0;
            st_d.as_hit = 1'b0;
            if (!st_q.acc.rnw) begin
                unique case (st_q.acc.ctl)
                    SEL_CTRL: begin
                        if (st_q.acc.hw) st_d.ctrl[WORD_W-1:HALF_W] = s_d;
                        else             st_d.ctrl[HALF_W-1:0]      = s_d;
                    end
                    SEL_ADDR: begin
                        if (st_q.acc.hw) st_d.addr[WORD_W-1:HALF_W] = s_d;
                        else             st_d.addr[HALF_W-1:0]      = s_d;
                    end
                    default: begin
                        if (!st_q.acc.hw) begin
                            st_d.wlo = s_d;
                        end else begin
                            st_d.data = {s_d, st_q.wlo};
                            st_d.req  = 1'b1;
                            st_d.we   = 1'b1;
                            st_d.inc  = (st_q.acc.ctl == SEL_DATA_INC);
                        end
                    end
                endcase
            end else if (st_q.acc.ctl == SEL_DATA_INC && st_q.acc.hw) begin
                // prefetch of the following word
                st_d.addr = st_q.addr + WORD_W'(ADDR_STEP);
                st_d.req  = 1'b1;
                st_d.we   = 1'b0;
                st_d.inc  = 1'b0;
            end
        end

        if (st_q.req && mem_ack) begin
            st_d.req = 1'b0;
            if (!st_q.we)              st_d.data = mem_rdata;
            if (st_q.we && st_q.inc)   st_d.addr = st_q.addr + WORD_W'(ADDR_STEP);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (st_q.acc.ctl)
            SEL_CTRL: rd_word = st_q.ctrl;
            SEL_ADDR: rd_word = st_q.addr;
            default:  rd_word = st_q.data;
        endcase
        rd_half = st_q.acc.hw ? rd_word[WORD_W-1:HALF_W] : rd_word[HALF_W-1:0];
    end

    assign drv_oe     = st_q.drv;
    assign host_d     = drv_oe ? rd_half : 'z;
    assign host_rdy_n = st_q.req & ~host_cs_n;
    assign mem_req    = st_q.req;
    assign mem_we     = st_q.we;
    assign mem_addr   = st_q.addr;
    assign mem_wdata  = st_q.data;
endmodule

// File: rtl/hpi_slave_chk.sv
module hpi_slave_chk #(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_cs_n,
    input logic              host_rdy_n,
    input logic              mem_req,
    input logic              mem_ack,
    input logic              mem_we,
    input logic [WORD_W-1:0] mem_addr,
    input logic [WORD_W-1:0] mem_wdata,
    input logic              drv_oe
);
    // R8
    rdy_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_cs_n |-> !host_rdy_n);

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> mem_req);

    // R11
    req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> ($stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));

    // R10
    bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cs_n && $past(host_cs_n, 1) && $past(host_cs_n, 2)
         && $past(host_cs_n, 3)) |-> !drv_oe);
endmodule

bind hpi_slave hpi_slave_chk #(.WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_cs_n (host_cs_n),
    .host_rdy_n(host_rdy_n),
    .mem_req   (mem_req),
    .mem_ack   (mem_ack),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .drv_oe    (drv_oe)
);

// File: tb/sim_hpi_slave.sv
module sim_hpi_slave;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_cs_n = 1'b1, host_ds1_n = 1'b1, host_ds2_n = 1'b1, host_as_n = 1'b1;
    logic [1:0]  host_ctl = 2'b00;
    logic        host_rnw = 1'b1, host_hw = 1'b0;
    wire  [15:0] host_d;
    logic        host_rdy_n, mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_ack;
    logic        tb_oe = 1'b0;
    logic [15:0] tb_d = '0;
    logic        mem_stall = 1'b0;
    logic [31:0] mem [16];
    logic [1:0]  dly;
    int          wcnt;
    int          total = 0, bad = 0, mon_bad = 0;

    always #2 clk = ~clk;

    assign host_d = tb_oe ? tb_d : 'z;

    hpi_slave u0 (
        .clk(clk), .rst_n(rst_n), .host_cs_n(host_cs_n), .host_ds1_n(host_ds1_n),
        .host_ds2_n(host_ds2_n), .host_as_n(host_as_n), .host_ctl(host_ctl),
        .host_rnw(host_rnw), .host_hw(host_hw), .host_d(host_d),
        .host_rdy_n(host_rdy_n), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack)
    );

    // memory model: acknowledge three cycles after a request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) mem[i] <= 32'hC0DE_0000 | i;
            mem_ack <= 1'b0; dly <= '0; wcnt <= 0; mem_rdata <= '0;
        end else begin
            mem_ack <= 1'b0;
            if (mem_req && !mem_ack && !mem_stall) begin
                if (dly == 2'd2) begin
                    dly <= '0;
                    mem_ack <= 1'b1;
                    if (mem_we) begin
                        mem[mem_addr[5:2]] <= mem_wdata;
                        wcnt <= wcnt + 1;
                    end else begin
                        mem_rdata <= mem[mem_addr[5:2]];
                    end
                end else begin
                    dly <= dly + 2'd1;
                end
            end
        end
    end

    // R11 monitor: pending request must hold its address
    logic        prev_wait = 1'b0;
    logic [31:0] prev_addr = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_wait && (!mem_req || mem_addr != prev_addr)) mon_bad++;
            prev_wait = mem_req && !mem_ack;
            prev_addr = mem_addr;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wait_ready(inout logic saw);
        int n = 0;
        while (host_rdy_n && n < 2000) begin
            saw = 1'b1;
            @(negedge clk);
            n++;
        end
        if (host_rdy_n) chk("R8 ready timeout", 32'd1, 32'd0);
    endtask

    task automatic host_acc(input logic [1:0] ctl, input logic hw, input logic rnw,
                            input logic [15:0] wd, input logic use_as, input logic both_ds,
                            output logic [15:0] rd, output logic saw);
        logic pre = 1'b0;
        @(negedge clk);
        host_ctl = ctl; host_hw = hw; host_rnw = rnw;
        tb_d = wd; tb_oe = !rnw;
        @(negedge clk);
        host_cs_n = 1'b0;
        @(negedge clk);
        wait_ready(pre);
        if (use_as) begin
            host_as_n = 1'b0;
            repeat (4) @(negedge clk);
            host_ctl = ~ctl; host_hw = ~hw;
        end
        host_ds1_n = 1'b0;
        if (both_ds) host_ds2_n = 1'b0;
        saw = 1'b0;
        repeat (6) begin
            @(negedge clk);
            if (host_rdy_n) saw = 1'b1;
        end
        wait_ready(saw);
        @(negedge clk);
        rd = host_d;
        host_ds1_n = 1'b1; host_ds2_n = 1'b1;
        repeat (4) @(negedge clk);
        host_as_n = 1'b1; host_cs_n = 1'b1; tb_oe = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // {ctl[1:0], hw, rnw, write data[15:0], expected read[15:0]}
    localparam logic [35:0] VECS [21] = '{
        {2'b10, 1'b0, 1'b0, 16'h0010, 16'h0000},
        {2'b10, 1'b1, 1'b0, 16'h0000, 16'h0000},
        {2'b10, 1'b0, 1'b1, 16'h0000, 16'h0010},  // R3 address readback
        {2'b00, 1'b0, 1'b0, 16'hA5A5, 16'h0000},
        {2'b00, 1'b1, 1'b0, 16'h5A5A, 16'h0000},
        {2'b00, 1'b0, 1'b1, 16'h0000, 16'hA5A5},  // R3 control low
        {2'b00, 1'b1, 1'b1, 16'h0000, 16'h5A5A},  // R3 control high
        {2'b11, 1'b0, 1'b1, 16'h0000, 16'h0004},  // R5 fetch low half
        {2'b11, 1'b1, 1'b1, 16'h0000, 16'hC0DE},  // R4 high half
        {2'b10, 1'b0, 1'b1, 16'h0000, 16'h0010},  // R7 address unchanged
        {2'b11, 1'b0, 1'b0, 16'h1111, 16'h0000},
        {2'b11, 1'b1, 1'b0, 16'h2222, 16'h0000},
        {2'b11, 1'b0, 1'b1, 16'h0000, 16'h1111},  // R4 word order
        {2'b11, 1'b1, 1'b1, 16'h0000, 16'h2222},
        {2'b01, 1'b0, 1'b0, 16'h3333, 16'h0000},
        {2'b01, 1'b1, 1'b0, 16'h4444, 16'h0000},
        {2'b10, 1'b0, 1'b1, 16'h0000, 16'h0014},  // R6 increment after write
        {2'b01, 1'b0, 1'b1, 16'h0000, 16'h0005},
        {2'b01, 1'b1, 1'b1, 16'h0000, 16'hC0DE},
        {2'b10, 1'b0, 1'b1, 16'h0000, 16'h0018},  // R6 increment after read
        {2'b11, 1'b0, 1'b1, 16'h0000, 16'h0006}   // R7 fixed read of new word
    };

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        logic        saw;
        int          w0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // reset state
        chk("R8 reset ready", {31'd0, host_rdy_n}, 32'd0);
        chk("R11 reset request", {31'd0, mem_req}, 32'd0);
        host_acc(2'b00, 1'b0, 1'b1, 16'h0, 1'b0, 1'b0, rd, saw);
        chk("R3 reset control", {16'd0, rd}, 32'h0);

        for (int i = 0; i < 21; i++) begin
            logic [35:0] v;
            v = VECS[i];
            host_acc(v[35:34], v[33], v[32], v[31:16], 1'b0, 1'b0, rd, saw);
            if (v[32]) chk($sformatf("R10 read vector %0d", i), {16'd0, rd}, {16'd0, v[15:0]});
            if (!v[34]) chk($sformatf("R9 no busy vector %0d", i), {31'd0, saw}, 32'd0);
            if (v[34] && v[32] && !v[33])
                chk($sformatf("R5 busy on fetch %0d", i), {31'd0, saw}, 32'd1);
        end
        chk("R6 incremented write word", mem[4], 32'h4444_3333);

        // R1: both data strobes low, nothing happens
        host_acc(2'b10, 1'b0, 1'b0, 16'h7777, 1'b0, 1'b1, rd, saw);
        host_acc(2'b10, 1'b0, 1'b1, 16'h0, 1'b0, 1'b0, rd, saw);
        chk("R1 ignored strobe pair", {16'd0, rd}, 32'h0018);

        // R2: selects taken from address strobe edge
        host_acc(2'b10, 1'b0, 1'b0, 16'h0020, 1'b1, 1'b0, rd, saw);
        host_acc(2'b10, 1'b0, 1'b1, 16'h0, 1'b0, 1'b0, rd, saw);
        chk("R2 address strobe latch", {16'd0, rd}, 32'h0020);

        // R4: first half alone does not write; R8 busy on chip select
        w0 = wcnt;
        host_acc(2'b11, 1'b0, 1'b0, 16'hAAAA, 1'b0, 1'b0, rd, saw);
        repeat (8) @(negedge clk);
        chk("R4 no write after first half", wcnt, w0);
        mem_stall = 1'b1;
        host_acc(2'b11, 1'b1, 1'b0, 16'hBBBB, 1'b0, 1'b0, rd, saw);
        chk("R8 ready low with cs high", {31'd0, host_rdy_n}, 32'd0);
        host_cs_n = 1'b0;
        #1;
        chk("R8 busy at cs fall", {31'd0, host_rdy_n}, 32'd1);
        mem_stall = 1'b0;
        repeat (10) @(negedge clk);
        chk("R8 ready after completion", {31'd0, host_rdy_n}, 32'd0);
        host_cs_n = 1'b1;
        chk("R4 posted word", mem[8], 32'hBBBB_AAAA);
        chk("R4 single write", wcnt, w0 + 1);
        chk("R11 request held stable", mon_bad, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule